// File: doc/BRIEF.md
# Serial Peripheral Interface Master with Queues

This block is a programmable serial shift engine that acts as the clock-driving side of an SPI link. Software loads outgoing words into an eight-entry transmit queue through a small word-indexed register bus. While the port is enabled, the engine pulls one word at a time and shifts it out MSB first on `mosi`. It shifts the reply in from `miso`, or from its own output when loopback is on, and stores the received word in an eight-entry receive queue, where software reads it back through the same data register.

The frame length runs from 4 to 16 bits. Clock idle level and capture edge are selectable. The bit time is the system clock divided by the product of an even prescaler and one plus an 8-bit rate field. Four interrupt causes exist: receive overrun, receive idle timeout, receive level and transmit level. Each cause can be read raw or after masking, and the two receive event causes are cleared by writing ones to a clear register. A chip select output stays low for the length of each frame.

Register index on `busAddr`: 0 data, 1 status, 2 frame setup, 3 mode, 4 prescaler, 5 interrupt mask, 6 raw interrupts, 7 masked interrupts, 8 interrupt clear, 9 transfer-request enables. Register reads return data in the same cycle. Writes take effect at the next clock edge.

Top module: `spm_top`

## Requirements
- R1: After reset the status register reads 0x03, the raw interrupt register reads 0x8, `irqOut` is 0, `csN` is 1 and `sclk` is 0.
- R2: A write to the data register queues the word for sending, and the write is dropped when the transmit queue already holds 8 words. A read of the data register returns the oldest received word and removes it, or returns 0 when the receive queue is empty.
- R3: Frame setup bits [3:0] hold the size code. The frame length is code+1 bits, and codes 0 to 2 give 4-bit frames. Bits go out MSB first, and the received word is right-aligned with its unused upper bits at zero.
- R4: Prescaler bits [7:1] are stored and bit 0 reads as 0. With P the stored even value (0 acts as 2) and S the rate field in frame setup bits [15:8], one bit lasts P*(1+S) clocks.
- R5: Frame setup bit 6 sets the `sclk` idle level and bit 7 selects capture on the first (0) or second (1) edge of each bit. `csN` is low while a frame runs.
- R6: With mode bit 0 set, the receive path takes the block's own serial output, and `miso` has no effect on the received word.
- R7: No frame starts while mode bit 1 (enable) is 0. Queued words stay queued and are sent once the bit is set.
- R8: Status bits: [0] transmit queue empty, [1] transmit queue not full, [2] receive queue not empty, [3] receive queue full, [4] busy (a frame is running or the transmit queue holds data).
- R9: A frame that completes while the receive queue holds 8 words sets raw interrupt bit 0 (overrun) and is discarded.
- R10: Raw interrupt bit 1 (timeout) sets after the receive queue has been non-empty with no push or pop for 32 bit times.
- R11: Raw bit 2 is 1 while the receive queue holds at least 4 words. Raw bit 3 is 1 while the transmit queue holds at most 4 words.
- R12: The masked interrupt register reads the raw bits ANDed with the mask register, and `irqOut` is the OR of the masked bits.
- R13: Writing 1 to clear-register bit 0 clears the overrun flag, and writing 1 to bit 1 clears the timeout flag. Writing 1 to bits 2 and 3 leaves the level flags unchanged.
- R14: Frame setup bits [5:4], mode bits [3:2] and transfer-request enable bits [1:0] are stored and read back. They do not change how frames run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register index |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (pops the receive queue at the data index) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the index |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low frame select |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
Register reads settle in the cycle that presents the index, so the bench samples `busRdata` a moment after driving the index, before the edge that pops. A written word starts its frame on the clock after the write edge and completes after 2N half-bit periods, so the bench polls the busy flag rather than counting edges. Bit timing is measured as the time between two rising `sclk` edges and compared to P*(1+S) clock periods. The timeout is due 32 bit times after the last receive push: one sample taken well before that instant must show the flag clear, and one taken well after must show it set, which keeps a one-cycle poll lag from mattering.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;
  localparam int WORD_W  = 16;
  localparam int HALF_W  = 15;
  localparam int LEN_W   = 5;

  localparam logic [3:0] IDX_DATA   = 4'd0;
  localparam logic [3:0] IDX_STAT   = 4'd1;
  localparam logic [3:0] IDX_FRAME  = 4'd2;
  localparam logic [3:0] IDX_MODE   = 4'd3;
  localparam logic [3:0] IDX_PRE    = 4'd4;
  localparam logic [3:0] IDX_MASK   = 4'd5;
  localparam logic [3:0] IDX_RAW    = 4'd6;
  localparam logic [3:0] IDX_MASKED = 4'd7;
  localparam logic [3:0] IDX_CLR    = 4'd8;
  localparam logic [3:0] IDX_REQ    = 4'd9;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [WORD_W-1:0] txWord;
  } spm_strobe_t;

  typedef struct packed {
    logic              enable;
    logic              loop;
    logic              cpol;
    logic              cpha;
    logic [LEN_W-1:0]  frameLen;
    logic [HALF_W-1:0] halfTicks;
  } spm_cfg_t;
endpackage

// File: rtl/spm_fifo.sv
`timescale 1ns/1ps
module spm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [W-1:0]               pushData,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          full, empty, doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CW'(1);
      else if (doPop && !doPush) count <= count - CW'(1);
    end
  end

  // R2
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/spm_datapath.sv
`timescale 1ns/1ps
module spm_datapath
  import spm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spm_strobe_t       stb,
  input  spm_cfg_t          cfg,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic [WORD_W-1:0] rxHead,
  output logic              running,
  output logic              rxPushed,
  output logic              overrunPulse
);
  logic [WORD_W-1:0] txHead, txShift, rxShift, rxNext, frameWord, lenMask;
  logic [HALF_W-1:0] halfCnt;
  logic [5:0]        edgeCnt, lastIdx;
  logic              startFrame, edgeNow, sampleEdge, shiftEdge, lastEdge;
  logic              serialIn, frameDone, rxFull, sclkQ;

  spm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pushData(stb.txWord),
    .pop(startFrame), .head(txHead), .count(txCount));

  spm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rstN(rstN), .push(frameDone), .pushData(frameWord),
    .pop(stb.rxPop), .head(rxHead), .count(rxCount));

  assign rxFull     = (rxCount == CW'(DEPTH));
  assign startFrame = !running && cfg.enable && (txCount != '0);
  assign edgeNow    = running && (halfCnt == '0);
  assign sampleEdge = cfg.cpha ? edgeCnt[0] : !edgeCnt[0];
  assign shiftEdge  = !sampleEdge && !(cfg.cpha && (edgeCnt == '0));
  assign lastIdx    = {cfg.frameLen, 1'b0} - 6'd1;
  assign lastEdge   = (edgeCnt == lastIdx);
  assign mosi       = txShift[4'(cfg.frameLen - LEN_W'(1))];
  assign serialIn   = cfg.loop ? mosi : miso;
  assign rxNext     = {rxShift[WORD_W-2:0], serialIn};
  assign lenMask    = WORD_W'((17'd1 << cfg.frameLen) - 17'd1);
  assign frameWord  = (sampleEdge ? rxNext : rxShift) & lenMask;
  assign frameDone  = edgeNow && lastEdge;
  assign rxPushed   = frameDone && !rxFull;
  assign overrunPulse = frameDone && rxFull;
  assign sclk       = sclkQ;
  assign csN        = !running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      txShift <= '0;
      rxShift <= '0;
      sclkQ   <= 1'b0;
    end else if (startFrame) begin
      running <= 1'b1;
      halfCnt <= cfg.halfTicks - HALF_W'(1);
      edgeCnt <= '0;
      txShift <= txHead;
      rxShift <= '0;
      sclkQ   <= cfg.cpol;
    end else if (running) begin
      if (halfCnt == '0) begin
        sclkQ   <= ~sclkQ;
        halfCnt <= cfg.halfTicks - HALF_W'(1);
        if (sampleEdge) rxShift <= rxNext;
        if (shiftEdge)  txShift <= txShift << 1;
        if (lastEdge) running <= 1'b0;
        else          edgeCnt <= edgeCnt + 6'd1;
      end else begin
        halfCnt <= halfCnt - HALF_W'(1);
      end
    end else begin
      sclkQ <= cfg.cpol;
    end
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && $past(!running)) |-> (sclk == $past(cfg.cpol)));

  // R7
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(cfg.enable));

  // R9
  drop_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrunPulse && !stb.rxPop) |=> (rxCount == $past(rxCount)));
endmodule

// File: rtl/spm_ctrl.sv
`timescale 1ns/1ps
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [WORD_W-1:0] rxHead,
  input  logic              running,
  input  logic              rxPushed,
  input  logic              overrunPulse,
  output spm_strobe_t       stb,
  output spm_cfg_t          cfg,
  output logic              irqOut
);
  localparam int TO_W = HALF_W + 6;

  logic [15:0]       frameReg;
  logic [3:0]        modeReg, maskReg;
  logic [6:0]        preReg;
  logic [1:0]        reqReg;
  logic              rawOvr, rawTo;
  logic [TO_W-1:0]   toCnt, toLimit;
  logic [6:0]        preHalf;
  logic [8:0]        scrP1;
  logic [3:0]        sizeCode, raw, masked;
  logic [4:0]        status;
  logic              rxEmpty, rxFull, txEmpty, txFull;
  logic              clrWr, toClr, toReset, toSet;

  assign rxEmpty = (rxCount == '0);
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign txFull  = (txCount == CW'(DEPTH));

  assign preHalf  = (preReg == '0) ? 7'd1 : preReg;
  assign scrP1    = {1'b0, frameReg[15:8]} + 9'd1;
  assign sizeCode = frameReg[3:0];

  always_comb begin
    cfg.enable    = modeReg[1];
    cfg.loop      = modeReg[0];
    cfg.cpol      = frameReg[6];
    cfg.cpha      = frameReg[7];
    cfg.frameLen  = (sizeCode < 4'd3) ? LEN_W'(4) : {1'b0, sizeCode} + LEN_W'(1);
    cfg.halfTicks = HALF_W'({8'd0, preHalf}) * HALF_W'({6'd0, scrP1});
    stb.txPush    = busWr && (busAddr == IDX_DATA);
    stb.txWord    = busWdata;
    stb.rxPop     = busRd && (busAddr == IDX_DATA) && !rxEmpty;
  end

  assign toLimit = {cfg.halfTicks, 6'd0};
  assign clrWr   = busWr && (busAddr == IDX_CLR);
  assign toClr   = clrWr && busWdata[1];
  assign toReset = rxEmpty || rxPushed || stb.rxPop || toClr;
  assign toSet   = !toReset && (toCnt == toLimit - TO_W'(1));

  assign raw    = {(txCount <= CW'(DEPTH/2)), (rxCount >= CW'(DEPTH/2)), rawTo, rawOvr};
  assign masked = raw & maskReg;
  assign irqOut = |masked;
  assign status = {running || !txEmpty, rxFull, !rxEmpty, !txFull, txEmpty};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      modeReg  <= '0;
      preReg   <= '0;
      maskReg  <= '0;
      reqReg   <= '0;
    end else if (busWr) begin
      case (busAddr)
        IDX_FRAME: frameReg <= busWdata;
        IDX_MODE:  modeReg  <= busWdata[3:0];
        IDX_PRE:   preReg   <= busWdata[7:1];
        IDX_MASK:  maskReg  <= busWdata[3:0];
        IDX_REQ:   reqReg   <= busWdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawOvr <= 1'b0;
      rawTo  <= 1'b0;
      toCnt  <= '0;
    end else begin
      if (overrunPulse)               rawOvr <= 1'b1;
      else if (clrWr && busWdata[0])  rawOvr <= 1'b0;
      if (toClr)      rawTo <= 1'b0;
      else if (toSet) rawTo <= 1'b1;
      if (toReset)                toCnt <= '0;
      else if (toCnt != toLimit)  toCnt <= toCnt + TO_W'(1);
    end
  end

  always_comb begin
    case (busAddr)
      IDX_DATA:   busRdata = rxEmpty ? '0 : rxHead;
      IDX_STAT:   busRdata = {11'd0, status};
      IDX_FRAME:  busRdata = frameReg;
      IDX_MODE:   busRdata = {12'd0, modeReg};
      IDX_PRE:    busRdata = {8'd0, preReg, 1'b0};
      IDX_MASK:   busRdata = {12'd0, maskReg};
      IDX_RAW:    busRdata = {12'd0, raw};
      IDX_MASKED: busRdata = {12'd0, masked};
      IDX_REQ:    busRdata = {14'd0, reqReg};
      default:    busRdata = '0;
    endcase
  end

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |=> rawOvr);

  // R13
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && busWdata[0] && !overrunPulse) |=> !rawOvr);

  // R10
  to_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawTo) |-> ($past(rxCount) != '0));

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irqOut);
endmodule

// File: rtl/spm_top.sv
`timescale 1ns/1ps
module spm_top
  import spm_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN,
  output logic        irqOut
);
  localparam int CW = $clog2(DEPTH+1);

  spm_strobe_t       stb;
  spm_cfg_t          cfg;
  logic [CW-1:0]     txCount, rxCount;
  logic [WORD_W-1:0] rxHead;
  logic              running, rxPushed, overrunPulse;

  spm_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .txCount(txCount),
    .rxCount(rxCount), .rxHead(rxHead), .running(running),
    .rxPushed(rxPushed), .overrunPulse(overrunPulse), .stb(stb), .cfg(cfg),
    .irqOut(irqOut));

  spm_datapath #(.DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .miso(miso), .sclk(sclk),
    .mosi(mosi), .csN(csN), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead), .running(running), .rxPushed(rxPushed),
    .overrunPulse(overrunPulse));
endmodule

// File: tb/test_spm_top.sv
`timescale 1ns/1ps
module test_spm_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        sclk, mosi, miso, csN, irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  logic [15:0] capWord = '0;
  logic [15:0] slvShift = 16'hFFFF;
  logic        capOn = 1'b0;
  logic        capRise = 1'b1;
  logic        slvSkip = 1'b0;
  int          benchLen = 8;

  assign miso = slvShift[benchLen-1];

  always #4 clk = ~clk;

  spm_top i_spm_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .irqOut(irqOut));

  always @(posedge sclk) if (capOn) begin
    if (capRise) capWord = {capWord[14:0], mosi};
    else if (slvSkip) slvSkip = 1'b0;
    else slvShift = slvShift << 1;
  end
  always @(negedge sclk) if (capOn) begin
    if (!capRise) capWord = {capWord[14:0], mosi};
    else if (slvSkip) slvSkip = 1'b0;
    else slvShift = slvShift << 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busW(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busR(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [15:0] st;
    for (int i = 0; i < 5000; i++) begin
      busR(4'd1, st);
      if (st[4] == 1'b0) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    busR(4'd1, d); chk("R1 R8 status", d, 32'h03);
    busR(4'd6, d); chk("R1 R11 raw", d, 32'h8);
    chk("R1 irqOut", irqOut, 0);
    chk("R1 csN", csN, 1);
    chk("R1 sclk", sclk, 0);
  endtask

  task automatic t_fields();
    logic [15:0] d;
    busW(4'd2, 16'h0037); busR(4'd2, d); chk("R14 frame fields", d, 32'h0037);
    busW(4'd3, 16'h000C); busR(4'd3, d); chk("R14 mode fields", d, 32'h000C);
    busW(4'd9, 16'h0003); busR(4'd9, d); chk("R14 request enables", d, 32'h3);
    busW(4'd4, 16'h0005); busR(4'd4, d); chk("R4 prescaler bit0", d, 32'h4);
    busW(4'd3, 16'h000F);
    busW(4'd0, 16'h0066); waitIdle();
    busR(4'd0, d); chk("R14 stored bits inert", d, 32'h66);
    busW(4'd9, 16'h0000); busW(4'd4, 16'h0002);
  endtask

  task automatic t_loopback();
    logic [15:0] d;
    slvShift = 16'hFFFF;
    busW(4'd2, 16'h0007); busW(4'd3, 16'h0003);
    busW(4'd0, 16'h00A5); waitIdle();
    busR(4'd0, d); chk("R6 loopback ignores miso", d, 32'hA5);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    busW(4'd3, 16'h0001);
    busW(4'd0, 16'h003C);
    repeat (50) @(posedge clk);
    busR(4'd1, d); chk("R7 R8 held while disabled", d, 32'h12);
    busR(4'd0, d); chk("R2 empty read", d, 32'h0);
    busW(4'd3, 16'h0003); waitIdle();
    busR(4'd1, d); chk("R8 status after frame", d, 32'h07);
    busR(4'd0, d); chk("R7 sent after enable", d, 32'h3C);
  endtask

  task automatic t_frameLen();
    logic [15:0] d;
    busW(4'd2, 16'h0001); busW(4'd0, 16'hFFFF); waitIdle();
    busR(4'd0, d); chk("R3 small code gives 4 bits", d, 32'h000F);
    busW(4'd2, 16'h000F); busW(4'd0, 16'hBEEF); waitIdle();
    busR(4'd0, d); chk("R3 16-bit frame", d, 32'hBEEF);
    busW(4'd2, 16'h000B); busW(4'd0, 16'hF5A3); waitIdle();
    busR(4'd0, d); chk("R3 12-bit frame", d, 32'h05A3);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    busW(4'd3, 16'h0002);
    for (int m = 0; m < 4; m++) begin
      logic cp, ch;
      logic [7:0] txw, rxw;
      cp = m[1]; ch = m[0];
      txw = 8'hC3 ^ 8'(m * 17);
      rxw = 8'h5A + 8'(m * 29);
      busW(4'd2, {8'h00, ch, cp, 6'h07});
      @(negedge clk);
      benchLen = 8; slvShift = {8'h00, rxw}; slvSkip = ch;
      capRise = (cp == ch); capWord = '0; capOn = 1'b1;
      busW(4'd0, {8'h00, txw}); waitIdle();
      capOn = 1'b0;
      chk($sformatf("R5 mode %0d mosi bits", m), capWord[7:0], txw);
      busR(4'd0, d);
      chk($sformatf("R5 mode %0d received", m), d, {24'h0, rxw});
      chk($sformatf("R5 mode %0d idle level", m), sclk, cp);
    end
    slvShift = 16'hFFFF;
  endtask

  task automatic measure(input logic [15:0] pre, input logic [15:0] frame, input int expClk, input string tag);
    realtime t0, t1;
    logic [15:0] d;
    busW(4'd4, pre); busW(4'd2, frame); busW(4'd3, 16'h0003);
    busW(4'd0, 16'h0055);
    @(posedge sclk); t0 = $realtime;
    #1 chk("R5 csN low in frame", csN, 0);
    @(posedge sclk); t1 = $realtime;
    chk(tag, int'((t1 - t0) / 8.0), expClk);
    waitIdle(); busR(4'd0, d);
  endtask

  task automatic t_rate();
    measure(16'h0004, 16'h0207, 12, "R4 bit time P4 S2");
    measure(16'h0005, 16'h0207, 12, "R4 odd prescale");
    measure(16'h0000, 16'h0007, 2, "R4 zero prescale");
    measure(16'h0002, 16'h0107, 4, "R4 bit time P2 S1");
    busW(4'd2, 16'h0007);
  endtask

  task automatic t_txfull();
    logic [15:0] d;
    busW(4'd3, 16'h0001);
    for (int i = 0; i < 9; i++) busW(4'd0, 16'(16'h10 + i));
    busR(4'd1, d); chk("R2 R8 transmit full", d, 32'h10);
    busW(4'd3, 16'h0003); waitIdle();
    busR(4'd1, d); chk("R8 R11 receive full", d, 32'h0F);
    busR(4'd6, d); chk("R11 both level flags", d & 16'hC, 32'hC);
    busW(4'd0, 16'h0099); waitIdle();
    busR(4'd6, d); chk("R9 overrun raised", d & 16'h1, 32'h1);
    for (int i = 0; i < 8; i++) begin
      busR(4'd0, d);
      chk($sformatf("R2 R9 word %0d kept", i), d, 32'(16'h10 + i));
    end
    busR(4'd1, d); chk("R9 R2 ninth discarded", d, 32'h03);
    busW(4'd8, 16'h000F);
    busR(4'd6, d); chk("R13 clear keeps level flags", d, 32'h8);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    busW(4'd8, 16'h0003);
    busW(4'd0, 16'h0042); waitIdle();
    repeat (30) @(posedge clk);
    busR(4'd6, d); chk("R10 not yet timed out", d & 16'h2, 32'h0);
    repeat (60) @(posedge clk);
    busR(4'd6, d); chk("R10 timed out", d & 16'h2, 32'h2);
    busW(4'd5, 16'h0002);
    busR(4'd7, d); chk("R12 masked timeout", d, 32'h2);
    chk("R12 irqOut on", irqOut, 1);
    busW(4'd8, 16'h0002);
    busR(4'd6, d); chk("R13 timeout cleared", d & 16'h2, 32'h0);
    chk("R12 irqOut off", irqOut, 0);
    busW(4'd5, 16'h0008);
    busR(4'd7, d); chk("R12 masked tx level", d, 32'h8);
    busW(4'd5, 16'h0000);
    busR(4'd0, d); chk("R2 drain", d, 32'h42);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_fields();
    t_loopback();
    t_disable();
    t_frameLen();
    t_modes();
    t_rate();
    t_txfull();
    t_timeout();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      report();
    end
  end
endmodule